// File: doc/BRIEF.md
# Virtual Output Queue Matching Scheduler

This block schedules fixed-length cells across an N×N input-queued switch. Every input keeps a separate waiting-cell count for each output, so the switch holds N×N counters in total. Each cycle stands for one cell time. In that cycle, every input may report one arriving cell, tagged with its destination output.

In each cell time the block looks at all counters and builds a matching in which no two edges share an input or an output. The weight of a pair is its queue length. Pairs are added heaviest first until no eligible pair is left, so the result is a greedy maximal matching. The block then registers that matching as the grant vector and removes one cell from every matched pair. The fabric uses the grant vector to move one cell from each granted input to its output in the next cell time. Because every output has its own queue at every input, a blocked head cell cannot stall cells at the same input that are bound for other outputs.

Top module: `voq_sched`

## Requirements
- R1: While `rst_n` is low, every counter is cleared and `gnt_valid` and `overflow` read zero. With no arrivals after reset, no grant is ever issued.
- R2: An arrival on `arr_valid[i]` with destination `arr_dst[i*IW +: IW] = j` adds one cell to pair (i,j), where IW = clog2(N).
- R3: A pair is granted only if its count was above zero in the cycle in which the matching was formed.
- R4: No two inputs are granted the same output in one cycle, and each input receives at most one output.
- R5: The matching is maximal. If an input i is not granted while pair (i,j) holds cells, then output j is granted to some other input.
- R6: Pairs are picked in order of decreasing count. Among equal counts, the lower input index wins, and then the lower output index.
- R7: Each grant removes exactly one cell from the granted pair.
- R8: When a pair receives an arrival and a grant in the same cycle, its count does not change.
- R9: Counters saturate at 2^CW−1 and never wrap. An arrival to a full counter that is not granted in that cycle leaves the counter at 2^CW−1 and raises `overflow` for exactly the following cycle.
- R10: The matching is formed from the counts held before a clock edge and is presented in the cycle after that edge. `gnt_valid[i]` marks input i as granted, and `gnt_dst[i*IW +: IW]` carries its output index. Both are valid for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell-time clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | N | One arrival flag per input |
| arr_dst | input | N*IW | Destination output of each input's arrival |
| gnt_valid | output | N | Input granted in this cell time |
| gnt_dst | output | N*IW | Output granted to each input |
| overflow | output | 1 | An arrival was lost to a full counter in the previous cycle |

## Verification
The bench builds the scheduler with N=4 and CW=3, so each counter saturates at seven cells. At that depth, three inputs that all target one output fill the shared column within a few dozen cycles, which puts saturation and the overflow pulse within reach of both directed and random traffic. With four inputs and four outputs, random arrivals produce frequent equal weights and competing columns. This exercises the greedy ordering and the tie rules, and every grant is compared against a reference model that tracks the counts cycle by cycle.

// File: rtl/voq_sched.sv
module voq_sched #(
  parameter int N  = 4,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    arr_valid,
  input  logic [N*$clog2(N)-1:0] arr_dst,
  output logic [N-1:0]    gnt_valid,
  output logic [N*$clog2(N)-1:0] gnt_dst,
  output logic            overflow
);
  localparam int IW = $clog2(N);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt   [N][N];
  logic [IW-1:0] a_dst [N];
  logic [IW-1:0] m_dst [N];
  logic [N-1:0]  m_v;
  logic          ovf_evt;

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign a_dst[g] = arr_dst[g*IW +: IW];
  end

  // greedy maximal matching: heaviest edge first, lowest input then output on ties
  always_comb begin
    logic [N-1:0]  row_free, col_free;
    logic [CW-1:0] best_w;
    logic [IW-1:0] bi, bj;
    logic          found;
    row_free = '1;
    col_free = '1;
    m_v      = '0;
    for (int i = 0; i < N; i++) m_dst[i] = '0;
    for (int k = 0; k < N; k++) begin
      best_w = '0;
      bi     = '0;
      bj     = '0;
      found  = 1'b0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (row_free[i] && col_free[j] && cnt[i][j] > best_w) begin
            best_w = cnt[i][j];
            bi     = IW'(i);
            bj     = IW'(j);
            found  = 1'b1;
          end
      if (found) begin
        row_free[bi] = 1'b0;
        col_free[bj] = 1'b0;
        m_v[bi]      = 1'b1;
        m_dst[bi]    = bj;
      end
    end
  end

  always_comb begin
    ovf_evt = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (arr_valid[i] && a_dst[i] == IW'(j) && !(m_v[i] && m_dst[i] == IW'(j))
            && cnt[i][j] == CMAX)
          ovf_evt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) cnt[i][j] <= '0;
      gnt_valid <= '0;
      gnt_dst   <= '0;
      overflow  <= 1'b0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (arr_valid[i] && a_dst[i] == IW'(j)) begin
            if (!(m_v[i] && m_dst[i] == IW'(j)) && cnt[i][j] != CMAX)
              cnt[i][j] <= cnt[i][j] + 1'b1;
          end else if (m_v[i] && m_dst[i] == IW'(j)) begin
            cnt[i][j] <= cnt[i][j] - 1'b1;
          end
        end
        gnt_dst[i*IW +: IW] <= m_dst[i];
      end
      gnt_valid <= m_v;
      overflow  <= ovf_evt;
    end
  end

  logic [N-1:0] col_taken;
  always_comb begin
    col_taken = '0;
    for (int i = 0; i < N; i++)
      if (gnt_valid[i]) col_taken[gnt_dst[i*IW +: IW]] = 1'b1;
  end

  for (genvar a = 0; a < N; a++) begin : g_chk_in
    for (genvar b = a + 1; b < N; b++) begin : g_pair
      // R4
      no_col_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid[a] && gnt_valid[b]) |-> gnt_dst[a*IW +: IW] != gnt_dst[b*IW +: IW]);
    end
    for (genvar c = 0; c < N; c++) begin : g_cell
      // R3
      grant_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid[a] && gnt_dst[a*IW +: IW] == IW'(c)) |-> $past(cnt[a][c]) != '0);
      // R5
      maximal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid[a] && $past(cnt[a][c]) != '0 && $past(rst_n)) |-> col_taken[c]);
      // R9
      no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt[a][c]) == CMAX) |-> cnt[a][c] >= CMAX - 1'b1);
      // R7
      step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[a][c] == $past(cnt[a][c])) || (cnt[a][c] == $past(cnt[a][c]) + 1'b1)
        || (cnt[a][c] == $past(cnt[a][c]) - 1'b1));
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (gnt_valid == '0 && !overflow));
endmodule

// File: tb/voq_sched_bench.sv
module voq_sched_bench;
  localparam int N = 4;
  localparam int CW = 3;
  localparam int IW = $clog2(N);
  localparam int CMAX = (1 << CW) - 1;
  localparam time PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] arr_valid = '0;
  logic [N*IW-1:0] arr_dst = '0;
  logic [N-1:0] gnt_valid;
  logic [N*IW-1:0] gnt_dst;
  logic overflow;

  voq_sched #(.N(N), .CW(CW)) u_voq_sched (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_dst(arr_dst),
    .gnt_valid(gnt_valid), .gnt_dst(gnt_dst), .overflow(overflow));

  always #(PERIOD/2) clk = ~clk;

  int total = 0, fails = 0;
  int mcnt [N][N];
  bit [N-1:0] ev;
  int ed [N];
  bit seen_ovf = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_match();
    bit [N-1:0] rf, cf;
    rf = '1; cf = '1; ev = '0;
    for (int i = 0; i < N; i++) ed[i] = 0;
    for (int k = 0; k < N; k++) begin
      int bw, bi, bj;
      bw = 0; bi = -1; bj = -1;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (rf[i] && cf[j] && mcnt[i][j] > bw) begin bw = mcnt[i][j]; bi = i; bj = j; end
      if (bi >= 0) begin rf[bi] = 0; cf[bj] = 0; ev[bi] = 1; ed[bi] = bj; end
    end
  endtask

  task automatic step(input logic [N-1:0] av, input logic [N*IW-1:0] ad);
    bit exp_ovf;
    bit [N-1:0] taken;
    arr_valid = av;
    arr_dst = ad;
    model_match();
    @(posedge clk); #1;
    exp_ovf = 0;
    for (int i = 0; i < N; i++) begin
      bit ok;
      ok = (gnt_valid[i] == ev[i]) && (!ev[i] || gnt_dst[i*IW +: IW] == IW'(ed[i]));
      chk(ok, "R6 greedy order", gnt_valid[i] ? int'(gnt_dst[i*IW +: IW]) : -1, ev[i] ? ed[i] : -1);
    end
    taken = '0;
    for (int i = 0; i < N; i++)
      if (gnt_valid[i]) begin
        chk(!taken[gnt_dst[i*IW +: IW]], "R4 output clash", i, -1);
        taken[gnt_dst[i*IW +: IW]] = 1;
      end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (!gnt_valid[i] && mcnt[i][j] > 0)
          chk(taken[j], "R5 maximal", 0, 1);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        bit inc, dec;
        inc = av[i] && ad[i*IW +: IW] == IW'(j);
        dec = ev[i] && ed[i] == j;
        if (inc && !dec) begin
          if (mcnt[i][j] == CMAX) exp_ovf = 1; else mcnt[i][j]++;
        end else if (dec && !inc) mcnt[i][j]--;
      end
    chk(overflow == exp_ovf, "R9 overflow", overflow, exp_ovf);
    if (overflow) seen_ovf = 1;
  endtask

  function automatic logic [N*IW-1:0] dsts(int d0, int d1, int d2, int d3);
    return {IW'(d3), IW'(d2), IW'(d1), IW'(d0)};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) mcnt[i][j] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(gnt_valid == '0, "R1 reset grants", gnt_valid, 0);
    chk(overflow == 1'b0, "R1 reset overflow", overflow, 0);
    rst_n = 1'b1;
    repeat (3) step('0, '0);
    chk(gnt_valid == '0, "R1 idle no grant", gnt_valid, 0);

    // R10: arrival counted at the edge, grant one cycle later
    step(4'b0010, dsts(0, 2, 0, 0));
    chk(gnt_valid == '0, "R10 no grant same cycle", gnt_valid, 0);
    step('0, '0);
    chk(gnt_valid == 4'b0010 && gnt_dst[IW +: IW] == 2, "R2 arrival granted", gnt_valid, 2);
    step('0, '0);
    chk(gnt_valid == '0, "R7 decremented to empty", gnt_valid, 0);
    chk(gnt_valid == '0, "R3 empty not granted", gnt_valid, 0);

    // R8: arrival during grant leaves count unchanged
    step(4'b0100, dsts(0, 0, 3, 0));
    step(4'b0100, dsts(0, 0, 3, 0));
    chk(gnt_valid == 4'b0100, "R8 first grant", gnt_valid, 4);
    step('0, '0);
    chk(gnt_valid == 4'b0100 && gnt_dst[2*IW +: IW] == 3, "R8 count held", gnt_valid, 4);
    step('0, '0);
    chk(gnt_valid == '0, "R8 drained", gnt_valid, 0);

    // R6 tie: inputs 0 and 1 both one cell for output 1 -> input 0 wins
    step(4'b0011, dsts(1, 1, 0, 0));
    step('0, '0);
    chk(gnt_valid == 4'b0001 && gnt_dst[0 +: IW] == 1, "R6 tie lower input", gnt_valid, 1);
    step('0, '0);
    chk(gnt_valid == 4'b0010, "R6 loser served next", gnt_valid, 2);

    // R9: three inputs flood output 0
    for (int c = 0; c < 40; c++) step(4'b0111, dsts(0, 0, 0, 0));
    chk(seen_ovf, "R9 overflow raised", seen_ovf, 1);
    for (int c = 0; c < 30; c++) step('0, '0);
    chk(gnt_valid == '0, "R7 all drained", gnt_valid, 0);

    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] av;
      logic [N*IW-1:0] ad;
      for (int i = 0; i < N; i++) begin
        av[i] = ($urandom_range(0, 9) < 7);
        ad[i*IW +: IW] = ($urandom_range(0, 3) == 0) ? IW'($urandom_range(0, N-1)) : IW'($urandom_range(0, 1));
      end
      step(av, ad);
    end
    summary();
  end
endmodule